// File: doc/BRIEF.md
# Thirteen-Pin GPIO Controller with Grouped Edge Interrupts

This block controls thirteen general-purpose pins through a byte-wide register bus with an address, a write enable, write data and combinational read data. Every pin owns two registers: an output-control register and an input-control register. The output-control register stores the driven value, the direction, the drive type and the pull selection. The drive type and direction shape the pad enable. The pull fields are kept only as stored bits. The input-control register reports the synchronised pin level and holds a 2-bit edge mode.

Each pin input passes through a two-flop synchroniser. A small per-pin state machine then tracks the last settled level. It has two states, `LVL_LOW` and `LVL_HIGH`, and two transitions that matter: `LVL_LOW -> LVL_HIGH` is a rise and `LVL_HIGH -> LVL_LOW` is a fall. When a transition matches the pin's edge mode, the matching bit latches in one of two status bytes. Pins 0 to 6 report to group 0 and pins 7 to 12 report to group 1. Each status byte has a mask byte beside it. A single interrupt line is high while any unmasked status bit is set. Software clears status bits by writing ones to them.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every output-control register reads 0x00, every edge mode is 0, both status bytes read 0x00, the mask bytes read 0x7F (group 0) and 0x3F (group 1), `irq` is low and no pad enable is high.
- R2: The output-control register of pin n is at address 0x00+n. It stores bits 5:0 as follows: bit 0 is the value, bits 2:1 are the pull select, bit 3 is the pull enable, bit 4 is push-pull (1) or open-drain (0), and bit 5 is output direction (1). Bits 7:6 read 0.
- R3: `pad_out[n]` equals bit 0 of the output-control register. `pad_oe[n]` is high only when bit 5 is 1 and either bit 4 is 1 or bit 0 is 0.
- R4: The input-control register of pin n is at address 0x10+n. Bit 0 reads the synchronised level, which reflects a pad change after two clock edges. Bits 2:1 store the edge mode. Writes to bit 0 and to bits 7:3 have no effect, and bits 7:3 read 0.
- R5: Edge mode 0 detects nothing, 1 detects falling edges, 2 detects rising edges and 3 detects both. A matching edge sets the pin's status bit on the third clock edge after the pad changes.
- R6: Status is at 0x20 (group 0) and 0x21 (group 1), and mask is at 0x22 and 0x23. Pin n < 7 uses bit n of group 0. Pin n >= 7 uses bit n-7 of group 1. The unused upper bits read 0.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A set status bit stays set until it is cleared.
- R8: If an edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R9: `irq` is high exactly when some status bit is set whose mask bit is 0. A mask bit of 1 blocks the interrupt but does not stop the status bit from latching.
- R10: Addresses outside the map read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wr_data | input | 8 | Write data |
| bus_rd_data | output | 8 | Read data for `bus_addr`, combinational |
| pad_in | input | 13 | Raw pin levels, asynchronous |
| pad_out | output | 13 | Value driven toward each pad |
| pad_oe | output | 13 | Pad output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check every cycle that a status bit only rises after a detected edge, that a detected edge always leaves its status bit set on the next cycle even under a clearing write, that a set bit survives any write that does not clear it, that a detected edge coincides with a change of the synchronised level, and that control writes land in the addressed register. Some behaviour only the bench scenarios can show. These are the exact latency from a pad change to a status bit, the choice each edge mode makes between rising and falling, the pin-to-group bit mapping, the open-drain enable rule, and the silence of unmapped addresses.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int DATA_W    = 8;
    localparam int CTRL_BITS = 6;

    // 2-bit edge selection held in the input-control register
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    // last settled level seen by the per-pin detector
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } level_state_e;

    // output-control fields, bit 5 down to bit 0
    typedef struct packed {
        logic       dir_out;
        logic       push_pull;
        logic       pull_en;
        logic [1:0] pull_sel;
        logic       value;
    } out_ctrl_t;

endpackage

// File: rtl/gpio_pin_edge.sv
module gpio_pin_edge
    import gpio_edge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pad_i,
    input  edge_mode_e mode_i,
    output logic       level_o,
    output logic       hit_o
);

    logic [1:0]   sync_q;
    level_state_e state_q;
    level_state_e state_d;
    logic         rise;
    logic         fall;

    // two-flop synchroniser
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], pad_i};
    end

    assign level_o = sync_q[1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (level_o)  state_d = LVL_HIGH;
            LVL_HIGH: if (!level_o) state_d = LVL_LOW;
        endcase
    end

    // outputs: transition type and mode filter
    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state_q)
            LVL_LOW:  rise = level_o;
            LVL_HIGH: fall = !level_o;
        endcase
        hit_o = 1'b0;
        unique case (mode_i)
            EDGE_OFF:  hit_o = 1'b0;
            EDGE_FALL: hit_o = fall;
            EDGE_RISE: hit_o = rise;
            EDGE_BOTH: hit_o = rise | fall;
        endcase
    end

    // a reported edge must coincide with a change of the settled level
    assert_edge_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> !$stable(level_o));

endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] hit_i,
    input  logic             clr_we_i,
    input  logic             mask_we_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] status_o,
    output logic [WIDTH-1:0] mask_o,
    output logic             irq_o
);

    logic [WIDTH-1:0] status_q;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] clr_vec;

    assign clr_vec = clr_we_i ? wdata_i : '0;

    // sticky status: a new edge outranks a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_vec) | hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_q <= '1;
        else if (mask_we_i) mask_q <= wdata_i;
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;
    assign irq_o    = |(status_q & ~mask_q);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit_chk
        assert_set_by_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_q[b]) |-> $past(hit_i[b]));
        assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            hit_i[b] |=> status_q[b]);
        assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[b] && !(clr_we_i && wdata_i[b])) |=> status_q[b]);
    end

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS    = 13,
    parameter int GROUP0_PINS = 7,
    parameter int ADDR_W      = 8,
    parameter int OUT_BASE    = 'h00,
    parameter int IN_BASE     = 'h10,
    parameter int IRQ_BASE    = 'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr_en,
    input  logic [DATA_W-1:0]   bus_wr_data,
    output logic [DATA_W-1:0]   bus_rd_data,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);

    localparam int GROUP1_PINS = NUM_PINS - GROUP0_PINS;
    localparam logic [ADDR_W-1:0] STAT0_A = ADDR_W'(IRQ_BASE);
    localparam logic [ADDR_W-1:0] STAT1_A = ADDR_W'(IRQ_BASE + 1);
    localparam logic [ADDR_W-1:0] MASK0_A = ADDR_W'(IRQ_BASE + 2);
    localparam logic [ADDR_W-1:0] MASK1_A = ADDR_W'(IRQ_BASE + 3);

    out_ctrl_t  out_ctrl_q [NUM_PINS];
    edge_mode_e mode_q     [NUM_PINS];
    logic [NUM_PINS-1:0] level;
    logic [NUM_PINS-1:0] hit;

    logic [GROUP0_PINS-1:0] stat0, mask0;
    logic [GROUP1_PINS-1:0] stat1, mask1;
    logic irq0, irq1;
    logic unused_hi_bits;

    assign unused_hi_bits = ^bus_wr_data[DATA_W-1:CTRL_BITS];

    // per-pin control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                out_ctrl_q[p] <= '0;
                mode_q[p]     <= EDGE_OFF;
            end
        end else if (bus_wr_en) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (bus_addr == ADDR_W'(OUT_BASE + p))
                    out_ctrl_q[p] <= out_ctrl_t'(bus_wr_data[CTRL_BITS-1:0]);
                if (bus_addr == ADDR_W'(IN_BASE + p))
                    mode_q[p] <= edge_mode_e'(bus_wr_data[2:1]);
            end
        end
    end

    // per-pin synchroniser, detector and pad drive
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_pin_edge u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .pad_i   (pad_in[p]),
            .mode_i  (mode_q[p]),
            .level_o (level[p]),
            .hit_o   (hit[p])
        );

        assign pad_out[p] = out_ctrl_q[p].value;
        assign pad_oe[p]  = out_ctrl_q[p].dir_out &
                            (out_ctrl_q[p].push_pull | ~out_ctrl_q[p].value);

        assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_en && bus_addr == ADDR_W'(OUT_BASE + p))
            |=> out_ctrl_q[p] == $past(bus_wr_data[CTRL_BITS-1:0]));
        assert_mode_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_en && bus_addr == ADDR_W'(IN_BASE + p))
            |=> mode_q[p] == $past(bus_wr_data[2:1]));
    end

    gpio_irq_group #(.WIDTH(GROUP0_PINS)) u_grp0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit[GROUP0_PINS-1:0]),
        .clr_we_i  (bus_wr_en && bus_addr == STAT0_A),
        .mask_we_i (bus_wr_en && bus_addr == MASK0_A),
        .wdata_i   (bus_wr_data[GROUP0_PINS-1:0]),
        .status_o  (stat0),
        .mask_o    (mask0),
        .irq_o     (irq0)
    );

    gpio_irq_group #(.WIDTH(GROUP1_PINS)) u_grp1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit[NUM_PINS-1:GROUP0_PINS]),
        .clr_we_i  (bus_wr_en && bus_addr == STAT1_A),
        .mask_we_i (bus_wr_en && bus_addr == MASK1_A),
        .wdata_i   (bus_wr_data[GROUP1_PINS-1:0]),
        .status_o  (stat1),
        .mask_o    (mask1),
        .irq_o     (irq1)
    );

    assign irq = irq0 | irq1;

    // read mux; unmapped addresses return zero
    always_comb begin
        bus_rd_data = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (bus_addr == ADDR_W'(OUT_BASE + p))
                bus_rd_data = {{(DATA_W-CTRL_BITS){1'b0}}, out_ctrl_q[p]};
            if (bus_addr == ADDR_W'(IN_BASE + p))
                bus_rd_data = {{(DATA_W-3){1'b0}}, mode_q[p], level[p]};
        end
        if (bus_addr == STAT0_A) bus_rd_data = DATA_W'(stat0);
        if (bus_addr == STAT1_A) bus_rd_data = DATA_W'(stat1);
        if (bus_addr == MASK0_A) bus_rd_data = DATA_W'(mask0);
        if (bus_addr == MASK1_A) bus_rd_data = DATA_W'(mask1);
    end

endmodule

// File: tb/test_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module test_gpio_edge_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_wr_data = '0;
    logic [7:0]  bus_rd_data;
    logic [12:0] pad_in = '0;
    logic [12:0] pad_out;
    logic [12:0] pad_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_edge_ctrl i_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rd_data, exp);
    endtask

    function automatic logic [7:0] stat_addr(int pin);
        return (pin < 7) ? 8'h20 : 8'h21;
    endfunction

    function automatic logic [7:0] pin_bit(int pin);
        return (pin < 7) ? 8'(1 << pin) : 8'(1 << (pin - 7));
    endfunction

    // drive a pad level and check status latency and outcome
    task automatic edge_case(string req, int pin, logic lvl, logic expect_set);
        wr(8'h20, 8'hFF);
        wr(8'h21, 8'hFF);
        pad_in[pin] = lvl;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd_chk({req, " latency"}, stat_addr(pin), 8'h00);
        @(posedge clk); @(negedge clk);
        rd_chk(req, stat_addr(pin), expect_set ? pin_bit(pin) : 8'h00);
    endtask

    task automatic t_reset;
        for (int p = 0; p < 13; p++) begin
            rd_chk("R1 out ctrl", 8'(p), 8'h00);
            rd_chk("R1 in ctrl", 8'(8'h10 + p), 8'h00);
        end
        rd_chk("R1 stat0", 8'h20, 8'h00);
        rd_chk("R1 stat1", 8'h21, 8'h00);
        rd_chk("R1 mask0", 8'h22, 8'h7F);
        rd_chk("R1 mask1", 8'h23, 8'h3F);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 pad_oe", {3'd0, pad_oe[12:8]}, 8'h00);
        check("R1 pad_oe lo", pad_oe[7:0], 8'h00);
    endtask

    task automatic t_regs;
        wr(8'h03, 8'hFF);
        rd_chk("R2 out ctrl upper bits", 8'h03, 8'h3F);
        wr(8'h0C, 8'h15);
        rd_chk("R2 out ctrl pin 12", 8'h0C, 8'h15);
        wr(8'h30, 8'hFF);
        wr(8'h0D, 8'hFF);
        rd_chk("R10 unmapped read 30", 8'h30, 8'h00);
        rd_chk("R10 unmapped read 0D", 8'h0D, 8'h00);
        rd_chk("R10 no side effect out", 8'h03, 8'h3F);
        rd_chk("R10 no side effect mask0", 8'h22, 8'h7F);
        rd_chk("R10 no side effect mask1", 8'h23, 8'h3F);
    endtask

    task automatic t_pad;
        #1;
        check("R3 pp out high value", {7'd0, pad_out[3]}, 8'h01);
        check("R3 pp out high oe", {7'd0, pad_oe[3]}, 8'h01);
        wr(8'h03, 8'h21);
        check("R3 od high value", {7'd0, pad_out[3]}, 8'h01);
        check("R3 od high oe", {7'd0, pad_oe[3]}, 8'h00);
        wr(8'h03, 8'h20);
        check("R3 od low oe", {7'd0, pad_oe[3]}, 8'h01);
        check("R3 od low value", {7'd0, pad_out[3]}, 8'h00);
        wr(8'h03, 8'h11);
        check("R3 input dir oe", {7'd0, pad_oe[3]}, 8'h00);
    endtask

    task automatic t_level;
        @(negedge clk);
        pad_in[5] = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_chk("R4 level after one edge", 8'h15, 8'h00);
        @(posedge clk); @(negedge clk);
        rd_chk("R4 level after two edges", 8'h15, 8'h01);
        wr(8'h15, 8'hFE);
        rd_chk("R4 mode stored bit0 ignored", 8'h15, 8'h07);
        wr(8'h15, 8'h00);
        pad_in[5] = 1'b0;
    endtask

    task automatic t_modes;
        wr(8'h12, 8'h04);
        edge_case("R5 rise mode rising", 2, 1'b1, 1'b1);
        edge_case("R5 rise mode falling", 2, 1'b0, 1'b0);
        wr(8'h12, 8'h02);
        edge_case("R5 fall mode rising", 2, 1'b1, 1'b0);
        edge_case("R5 fall mode falling", 2, 1'b0, 1'b1);
        wr(8'h12, 8'h06);
        edge_case("R5 both mode rising", 2, 1'b1, 1'b1);
        edge_case("R5 both mode falling", 2, 1'b0, 1'b1);
        wr(8'h12, 8'h00);
        edge_case("R5 off mode rising", 2, 1'b1, 1'b0);
        edge_case("R5 off mode falling", 2, 1'b0, 1'b0);
    endtask

    task automatic t_groups;
        wr(8'h16, 8'h04);
        wr(8'h17, 8'h04);
        wr(8'h1C, 8'h04);
        edge_case("R6 pin 6 group0 bit6", 6, 1'b1, 1'b1);
        edge_case("R6 pin 7 group1 bit0", 7, 1'b1, 1'b1);
        edge_case("R6 pin 12 group1 bit5", 12, 1'b1, 1'b1);
        rd_chk("R6 group0 untouched", 8'h20, 8'h00);
    endtask

    task automatic t_clear_and_irq;
        // pin 7 and pin 12 both pending in group 1
        wr(8'h1C, 8'h02);
        wr(8'h17, 8'h02);
        @(negedge clk);
        pad_in[7] = 1'b0; pad_in[12] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd_chk("R9 masked still latches", 8'h21, 8'h21);
        check("R9 masked irq low", {7'd0, irq}, 8'h00);
        wr(8'h21, 8'h01);
        rd_chk("R7 one clears bit0", 8'h21, 8'h20);
        wr(8'h21, 8'h00);
        rd_chk("R7 zero leaves bits", 8'h21, 8'h20);
        wr(8'h23, 8'h1F);
        check("R9 unmasked irq high", {7'd0, irq}, 8'h01);
        wr(8'h23, 8'h3F);
        check("R9 remasked irq low", {7'd0, irq}, 8'h00);
        wr(8'h23, 8'h1F);
        wr(8'h21, 8'h20);
        check("R9 cleared irq low", {7'd0, irq}, 8'h00);
        rd_chk("R7 clear last bit", 8'h21, 8'h00);
        wr(8'h23, 8'h3F);
    endtask

    task automatic t_edge_wins;
        wr(8'h19, 8'h06);
        edge_case("R8 setup rise", 9, 1'b1, 1'b1);
        @(negedge clk);
        pad_in[9] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 8'h21; bus_wr_data = 8'h04; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        rd_chk("R8 edge beats clear", 8'h21, 8'h04);
        wr(8'h21, 8'h04);
        rd_chk("R8 later clear works", 8'h21, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_pad();
        t_level();
        t_modes();
        t_groups();
        t_clear_and_irq();
        t_edge_wins();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule